// File: doc/BRIEF.md
# Sample-Rate PLL Divider Encoder

This block turns a requested audio sample rate, given in hertz, into the 12-bit control word of a clock-synthesis PLL that runs from a 28.224 MHz reference. It also reports the rate that the PLL will actually produce. The control word has two parts: a range code in its upper bits selects a prescale range, and its low nine bits hold a divider. The divider is the raw ratio shifted right by zero, one or two places, depending on how large the raw ratio is.

A request starts with a one-cycle `start` pulse. The rate is sampled in that cycle. The block first computes the raw ratio, which is twice the reference divided by the rate. It then picks the range and forms the effective divider. Last, it divides the reference by the effective divider plus one to obtain the achieved rate. Both divisions run on one shared serial divider that produces one quotient bit per cycle.

When a result is ready, `done` pulses for one cycle and the word appears on a high-byte output and a low-byte output. A rate outside the supported window is refused at once: the error flag is raised and the outputs keep their previous values. The lowest range (raw ratio below 0x100, code 0xC00) is encoded, but no rate inside the window can reach it.

Top module: `srate_pll_enc`

## Requirements
- R1: After reset, `busy`, `done` and `range_err` are 0, and `pll_hi`, `pll_lo` and `achieved_hz` are all zero.
- R2: A request whose rate is below 6900 or above 219000 gives `done` together with `range_err`=1 in the cycle after `start`. `pll_hi`, `pll_lo` and `achieved_hz` keep their previous values.
- R3: For an accepted rate, the raw ratio is 56448000 divided by the rate, rounded down.
- R4: The 12-bit word is encoded from the raw ratio as follows, checked in this order:
  - below 0x100: raw + 0xC00
  - below 0x200: raw + 0x800
  - below 0x400: raw AND 0x1FF
  - below 0x800: ((raw>>1) AND 0x1FF) + 0x200
  - otherwise: ((raw>>2) AND 0x1FF) + 0x400
- R5: `pll_hi` carries word bits [11:8] in its bits [3:0], and its bits [7:4] are zero. `pll_lo` carries word bits [7:0].
- R6: `achieved_hz` is 28224000 divided by (effective divider + 1), rounded down. The effective divider is the raw ratio shifted right by the same amount that the chosen range used (0, 1 or 2).
- R7: `start` is taken only while `busy` is low. `busy` stays high from the cycle after an accepted `start` until the result is out. `done` is high for exactly one cycle. A `start` pulse while busy is ignored and does not change the result in progress.
- R8: The window edges 6900 and 219000 are accepted. A successful result clears `range_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request pulse; `rate_hz` is sampled with it |
| rate_hz | input | 18 | Requested sample rate in Hz |
| busy | output | 1 | A computation is in progress |
| done | output | 1 | One-cycle pulse when a request finishes |
| range_err | output | 1 | The last request was outside the window |
| pll_hi | output | 8 | Word bits [11:8] in bits [3:0]; bits [7:4] are zero |
| pll_lo | output | 8 | Word bits [7:0] |
| achieved_hz | output | 18 | Rate the PLL produces with the word, in Hz |

## Verification
The assertions assume that the shared divider never receives a zero divisor. That holds because a rate is only passed on after the window test, and the second division always divides by the effective divider plus one. They also assume that a new operand load reaches the divider only while it is idle. The stimulus keeps to this: each request is a single-cycle `start` pulse, followed by a wait for `done`. The random rates are drawn across the window and a few kilohertz past both of its edges, so accepted and refused requests are mixed. One deliberate `start` pulse is also issued in the middle of a computation.

// File: rtl/srpll_pkg.sv
package srpll_pkg;

  // Dividend width: holds twice the 28.224 MHz reference.
  localparam int DIV_W = 26;

  typedef logic [DIV_W-1:0] divw_t;

  typedef struct packed {
    logic [11:0] code;  // range code and divider, 12 bits
    divw_t       eff;   // raw ratio after the range shift
  } enc_t;

  // Piecewise range encoding of the raw ratio.
  function automatic enc_t encode_raw(divw_t raw);
    enc_t e;
    if (raw < divw_t'(12'h100)) begin
      e.code = {3'b110, raw[8:0]};
      e.eff  = raw;
    end else if (raw < divw_t'(12'h200)) begin
      e.code = {3'b100, raw[8:0]};
      e.eff  = raw;
    end else if (raw < divw_t'(12'h400)) begin
      e.code = {3'b000, raw[8:0]};
      e.eff  = raw;
    end else if (raw < divw_t'(12'h800)) begin
      e.code = {3'b001, raw[9:1]};
      e.eff  = raw >> 1;
    end else begin
      e.code = {3'b010, raw[10:2]};
      e.eff  = raw >> 2;
    end
    return e;
  endfunction

endpackage

// File: rtl/srpll_divider.sv
module srpll_divider #(
  parameter int W = 26
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] quotient
);
  localparam int CW = $clog2(W + 1);

  logic [W:0]    rem_q;
  logic [W-1:0]  quo_q;
  logic [W-1:0]  dsr_q;
  logic [CW-1:0] cnt_q;
  logic [W:0]    rem_sh;
  logic          fits;

  // Restoring step: bring down the next dividend bit and try a subtract.
  assign rem_sh = {rem_q[W-1:0], quo_q[W-1]};
  assign fits   = rem_sh >= {1'b0, dsr_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      quo_q <= '0;
      dsr_q <= '0;
      cnt_q <= '0;
      busy  <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        rem_q <= '0;
        quo_q <= dividend;
        dsr_q <= divisor;
        cnt_q <= CW'(W);
        busy  <= 1'b1;
      end else if (busy) begin
        rem_q <= fits ? (rem_sh - {1'b0, dsr_q}) : rem_sh;
        quo_q <= {quo_q[W-2:0], fits};
        cnt_q <= cnt_q - CW'(1);
        if (cnt_q == CW'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign quotient = quo_q;

  AST_REM_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (rem_q < {1'b0, dsr_q})); // R3
  AST_NO_RELOAD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy); // R7

endmodule

// File: rtl/srpll_range_enc.sv
module srpll_range_enc
  import srpll_pkg::*;
(
  input  divw_t       raw,
  output logic [11:0] code,
  output divw_t       eff
);
  enc_t enc;

  always_comb begin
    enc  = encode_raw(raw);
    code = enc.code;
    eff  = enc.eff;
  end

endmodule

// File: rtl/srate_pll_enc.sv
module srate_pll_enc
  import srpll_pkg::*;
#(
  parameter int RATE_W = 18,
  parameter int MIN_HZ = 6900,
  parameter int MAX_HZ = 219000,
  parameter int REF_HZ = 28224000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [RATE_W-1:0] rate_hz,
  output logic              busy,
  output logic              done,
  output logic              range_err,
  output logic [7:0]        pll_hi,
  output logic [7:0]        pll_lo,
  output logic [RATE_W-1:0] achieved_hz
);
  localparam divw_t RAW_NUM = divw_t'(2 * REF_HZ);
  localparam divw_t ACH_NUM = divw_t'(REF_HZ);

  typedef enum logic [1:0] {ST_IDLE, ST_RAW, ST_ACH} st_e;

  st_e   st_q;
  logic  in_window;
  logic  go_div;
  logic  div_start;
  logic  div_busy;
  logic  div_done;
  divw_t div_a;
  divw_t div_b;
  divw_t div_quo;
  logic [11:0] enc_code;
  divw_t       enc_eff;
  logic [11:0] code_q;
  logic [11:0] word_q;
  logic [RATE_W-1:0] ach_q;

  assign in_window = (rate_hz >= RATE_W'(MIN_HZ)) && (rate_hz <= RATE_W'(MAX_HZ));
  assign go_div    = (st_q == ST_IDLE) && start && in_window;
  assign div_start = go_div || ((st_q == ST_RAW) && div_done);
  assign div_a     = (st_q == ST_IDLE) ? RAW_NUM : ACH_NUM;
  assign div_b     = (st_q == ST_IDLE) ? divw_t'(rate_hz) : (enc_eff + divw_t'(1));

  srpll_divider #(.W(DIV_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (div_start),
    .dividend (div_a),
    .divisor  (div_b),
    .busy     (div_busy),
    .done     (div_done),
    .quotient (div_quo)
  );

  srpll_range_enc u_enc (
    .raw  (div_quo),
    .code (enc_code),
    .eff  (enc_eff)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      done      <= 1'b0;
      range_err <= 1'b0;
      code_q    <= '0;
      word_q    <= '0;
      ach_q     <= '0;
    end else begin
      done <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start) begin
          if (in_window) begin
            st_q <= ST_RAW;
          end else begin
            done      <= 1'b1;
            range_err <= 1'b1;
          end
        end
        ST_RAW: if (div_done) begin
          code_q <= enc_code;
          st_q   <= ST_ACH;
        end
        ST_ACH: if (div_done) begin
          word_q    <= code_q;
          ach_q     <= div_quo[RATE_W-1:0];
          range_err <= 1'b0;
          done      <= 1'b1;
          st_q      <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy        = (st_q != ST_IDLE);
  assign pll_hi      = {4'b0000, word_q[11:8]};
  assign pll_lo      = word_q[7:0];
  assign achieved_hz = ach_q;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R7
  AST_REJECT_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && range_err) |-> ($past(rate_hz) < RATE_W'(MIN_HZ) || $past(rate_hz) > RATE_W'(MAX_HZ))); // R2
  AST_REJECT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (done && range_err) |-> ($stable(pll_hi) && $stable(pll_lo) && $stable(achieved_hz))); // R2
  AST_LEGAL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !range_err) |-> (pll_hi[7:4] == 4'h0 && pll_hi[3:1] inside {3'd0, 3'd1, 3'd2, 3'd4, 3'd6})); // R4

endmodule

// File: tb/srate_pll_enc_bench.sv
module srate_pll_enc_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [17:0] rate_hz = '0;
  logic        busy, done, range_err;
  logic [7:0]  pll_hi, pll_lo;
  logic [17:0] achieved_hz;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  int prev_word = 0;
  int prev_ach = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc++;

  srate_pll_enc u_srate_pll_enc (
    .clk(clk), .rst_n(rst_n), .start(start), .rate_hz(rate_hz),
    .busy(busy), .done(done), .range_err(range_err),
    .pll_hi(pll_hi), .pll_lo(pll_lo), .achieved_hz(achieved_hz)
  );

  function automatic int shift_of(int raw);
    if (raw >= 2048) return 2;
    if (raw >= 1024) return 1;
    return 0;
  endfunction

  function automatic int word_of(int raw);
    int d;
    d = raw / (1 << shift_of(raw));
    if (raw < 256)  return 3072 + raw;
    if (raw < 512)  return 2048 + raw;
    if (raw < 1024) return raw % 512;
    if (raw < 2048) return 512 + (d % 512);
    return 1024 + (d % 512);
  endfunction

  function automatic int ach_of(int raw);
    return 28224000 / ((raw / (1 << shift_of(raw))) + 1);
  endfunction

  task automatic check(string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic wait_done();
    int w = 0;
    while (!done && w < 300) begin
      @(negedge clk);
      w++;
    end
    check("R7 done arrives", int'(done), 1);
  endtask

  task automatic run(int r);
    bit ok;
    int raw;
    ok = (r >= 6900) && (r <= 219000);
    @(negedge clk);
    rate_hz = 18'(r);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (ok) check("R7 busy after start", int'(busy), 1);
    wait_done();
    if (!ok) begin
      check("R2 error flag", int'(range_err), 1);
      check("R2 word kept", {pll_hi, pll_lo}, prev_word);
      check("R2 achieved kept", int'(achieved_hz), prev_ach);
    end else begin
      raw = 56448000 / r;
      check("R8 error cleared", int'(range_err), 0);
      check("R3/R4 word", {pll_hi, pll_lo}, word_of(raw));
      check("R5 high nibble zero", int'(pll_hi[7:4]), 0);
      check("R6 achieved rate", int'(achieved_hz), ach_of(raw));
      prev_word = {pll_hi, pll_lo};
      prev_ach = int'(achieved_hz);
    end
    @(negedge clk);
    check("R7 done one cycle", int'(done), 0);
  endtask

  initial begin
    wait (cyc >= 150000);
    n_bad++;
    $display("FAIL watchdog: actual=%0d expected=<150000 cycles", cyc);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int r;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 busy", int'(busy), 0);
    check("R1 done", int'(done), 0);
    check("R1 err", int'(range_err), 0);
    check("R1 word", {pll_hi, pll_lo}, 0);
    check("R1 achieved", int'(achieved_hz), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    run(6899);   // R2 below window before any result
    run(6900);   // R8 lower edge
    run(219000); // R8 upper edge
    run(219001); // R2 above window
    run(0);
    run(48000);
    run(44100);
    run(96000);
    run(192000);
    run(8000);
    run(27000);
    run(110000);

    // R7 start during busy is ignored
    @(negedge clk);
    rate_hz = 18'd32000;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    rate_hz = 18'd96000;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done();
    check("R7 ignored start word", {pll_hi, pll_lo}, word_of(56448000 / 32000));
    check("R7 ignored start achieved", int'(achieved_hz), ach_of(56448000 / 32000));
    prev_word = {pll_hi, pll_lo};
    prev_ach = int'(achieved_hz);
    repeat (70) @(negedge clk);
    check("R7 no second result", int'(busy), 0);

    for (int i = 0; i < 60; i++) begin
      r = 3000 + int'($urandom % 222000);
      run(r);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule